// File: doc/BRIEF.md
# Four-Function Up/Down Counter

This block is a synchronous binary counter, four bits wide by default. On each rising clock edge a two-bit operation code picks one of four actions: keep the value, add one, subtract one, or take a new value from a parallel data input. The count wraps around at both ends, so it runs modulo 2^W in either direction.

An active-low asynchronous reset clears the count at once and keeps it at zero for as long as it is held. The operation code and the data input act only through the clock edge. They have no combinational path to the output, so a surrounding circuit may change them at any point in the cycle.

Top module: `fc_updown`

## Requirements
- R1: Pulling `rst_n` low sets `count` to zero at once, without waiting for a clock edge.
- R2: While `rst_n` is low, `count` stays at zero on every clock edge, whatever the values of `func_sel` and `load_val`.
- R3: With `func_sel` = 2'b00, a rising edge leaves `count` unchanged, even while `load_val` changes.
- R4: With `func_sel` = 2'b01, a rising edge raises `count` by one.
- R5: With `func_sel` = 2'b10, a rising edge lowers `count` by one.
- R6: With `func_sel` = 2'b11, a rising edge copies `load_val` into `count`.
- R7: Counting up from the all-ones value (15 at the default width) gives zero.
- R8: Counting down from zero gives the all-ones value (15 at the default width).
- R9: A change on `func_sel` or `load_val` between edges leaves `count` unchanged until the next rising edge.
- R10: The first rising edge after `rst_n` returns high carries out the selected operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| func_sel | input | 2 | Operation code: 00 keep, 01 up, 10 down, 11 load |
| load_val | input | W (4) | Parallel value taken in on a load |
| count | output | W (4) | Current count |

## Verification
The clocked assertions assume that `func_sel` and `load_val` hold known, steady values at each rising edge. They also assume that `rst_n` never changes at a rising edge, because the edge could then be read as either a reset or a count. The bench keeps to this. It drives every input on the falling edge, or at a fixed offset into the high phase, and it releases reset only on a falling edge. The decode check is skipped while the operation code is still unknown.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Operation codes; the encoding is part of the block's behaviour.
  typedef enum logic [1:0] {
    FC_KEEP = 2'b00,
    FC_UP   = 2'b01,
    FC_DOWN = 2'b10,
    FC_LOAD = 2'b11
  } fc_op_e;

  // Decoded events, exactly one active per cycle.
  typedef struct packed {
    logic keep;
    logic up;
    logic down;
    logic load;
  } fc_evt_t;

  localparam int unsigned FC_EVT_N = 4;

endpackage

// File: rtl/fc_decode.sv
module fc_decode
  import fc_pkg::*;
(
  input  logic [1:0] sel,
  output fc_evt_t    evt
);

  fc_op_e op;

  always_comb begin
    op  = fc_op_e'(sel);
    evt = '0;
    unique case (op)
      FC_KEEP: evt.keep = 1'b1;
      FC_UP:   evt.up   = 1'b1;
      FC_DOWN: evt.down = 1'b1;
      FC_LOAD: evt.load = 1'b1;
      default: evt.keep = 1'b1;
    endcase
  end

  // R3 R4 R5 R6: every known operation code raises exactly one event
  always_comb begin
    if (!$isunknown(sel)) begin
      evt_onehot_chk: assert ($countones(evt) == 1)
        else $error("decode produced %0d events", $countones(evt));
    end
  end

endmodule

// File: rtl/fc_next.sv
module fc_next
  import fc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load_val,
  input  fc_evt_t      evt,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Modulo 2^W arithmetic; the carry out of the top bit is dropped on purpose.
  function automatic logic [W-1:0] wrap_inc(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [W-1:0] wrap_dec(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  always_comb begin
    nxt = cur;
    if (evt.up)        nxt = wrap_inc(cur);
    else if (evt.down) nxt = wrap_dec(cur);
    else if (evt.load) nxt = load_val;
  end

endmodule

// File: rtl/fc_reg.sv
module fc_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R2
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> q == '0)
    else $error("count not cleared under reset");

endmodule

// File: rtl/fc_updown.sv
module fc_updown
  import fc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   func_sel,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ALL_ONES = '1;

  fc_evt_t      evt;
  logic [W-1:0] nxt;

  // Named events for the assertions
  logic step_up, step_dn, take_load, keep_val;
  assign step_up   = evt.up;
  assign step_dn   = evt.down;
  assign take_load = evt.load;
  assign keep_val  = evt.keep;

  fc_decode u_decode (
    .sel (func_sel),
    .evt (evt)
  );

  fc_next #(.W(W)) u_next (
    .cur      (count),
    .load_val (load_val),
    .evt      (evt),
    .nxt      (nxt)
  );

  fc_reg #(.W(W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (count)
  );

  // R3
  keep_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_val |=> $stable(count))
    else $error("count moved on keep");

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> count == W'($past(count) + 1'b1))
    else $error("count did not step up");

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> count == W'($past(count) - 1'b1))
    else $error("count did not step down");

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |=> count == $past(load_val))
    else $error("count did not take load value");

  // R7
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && count == ALL_ONES) |=> count == '0)
    else $error("up wrap failed");

  // R8
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && count == '0) |=> count == ALL_ONES)
    else $error("down wrap failed");

endmodule

// File: tb/fc_updown_bench.sv
module fc_updown_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] func_sel;
  logic [3:0] load_val;
  logic [3:0] count;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fc_updown #(.W(4)) u_fc_updown (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_sel (func_sel),
    .load_val (load_val),
    .count    (count)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_cmp++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp, $time);
    end
  endtask

  // Drive on the falling edge, sample 5 ns after the rising edge.
  task automatic step(input logic [1:0] op, input logic [3:0] val);
    @(negedge clk);
    func_sel = op;
    load_val = val;
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset_start;
    @(posedge clk); #5;
    check("R1", 4'd0);
    @(negedge clk);
    func_sel = 2'b01;
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R10", 4'd1);
  endtask

  task automatic t_load;
    step(2'b11, 4'd5);
    check("R6", 4'd5);
    step(2'b11, 4'd10);
    check("R6", 4'd10);
  endtask

  task automatic t_keep;
    step(2'b00, 4'd3);
    check("R3", 4'd10);
    step(2'b00, 4'd12);
    check("R3", 4'd10);
    #3 load_val = 4'd1;
    step(2'b00, 4'd7);
    check("R3", 4'd10);
  endtask

  task automatic t_up;
    step(2'b11, 4'd13);
    step(2'b01, 4'd0);
    check("R4", 4'd14);
    step(2'b01, 4'd0);
    check("R4", 4'd15);
    step(2'b01, 4'd0);
    check("R7", 4'd0);
    step(2'b01, 4'd0);
    check("R4", 4'd1);
  endtask

  task automatic t_down;
    step(2'b11, 4'd2);
    step(2'b10, 4'd0);
    check("R5", 4'd1);
    step(2'b10, 4'd0);
    check("R5", 4'd0);
    step(2'b10, 4'd0);
    check("R8", 4'd15);
    step(2'b10, 4'd0);
    check("R5", 4'd14);
  endtask

  task automatic t_sel_timing;
    // now 5 ns after a rising edge, count = 14
    func_sel = 2'b11;
    load_val = 4'd9;
    #4;
    check("R9", 4'd14);
    func_sel = 2'b01;
    #3;
    check("R9", 4'd14);
    func_sel = 2'b11;
    @(posedge clk); #5;
    check("R9", 4'd9);
  endtask

  task automatic t_reset_mid;
    // 5 ns after a rising edge, count = 9
    rst_n = 1'b0;
    #2;
    check("R1", 4'd0);
    step(2'b01, 4'd0);
    check("R2", 4'd0);
    step(2'b11, 4'd6);
    check("R2", 4'd0);
    step(2'b10, 4'd0);
    check("R2", 4'd0);
    @(negedge clk);
    func_sel = 2'b10;
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R10", 4'd15);
  endtask

  initial begin
    rst_n = 1'b1;
    func_sel = 2'b00;
    load_val = 4'd0;
    #1 rst_n = 1'b0;
    t_reset_start();
    t_load();
    t_keep();
    t_up();
    t_down();
    t_sel_timing();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule